// File: doc/BRIEF.md
# Smart Card Transmit Status Flags

This block holds the three status flags of a half-duplex, character-based smart card transmitter: a parity-error flag, a transmit-data-empty flag and a transmit-end flag. It listens to event pulses from the character transmitter and receiver: the start of each character, a parity error, and a half-element-time tick. It also watches two level inputs, the transmit enable and the error-signal status reported by the receiving side. Two mode bits choose how long after a character starts the transmit-end flag may rise.

Software sees the flags through a status read strobe and clears them with a write. A flag is cleared by writing 0 to its bit, but only if a status read since the flag rose returned it as 1. A DMA acknowledge, issued when a DMA engine has refilled the data register, clears the data-empty and transmit-end flags without any read. The guard delay is counted in half element times, so the fractional delays become whole tick counts.

Top module: `sc_tx_status`

## Requirements
- R1: After reset the status word reads parity error 0 (bit 0), data empty 1 (bit 1) and transmit end 1 (bit 2).
- R2: A parity-error pulse from the receiver sets bit 0 in the following cycle.
- R3: A write clears bit 0 only if the written bit 0 is 0 and a status read returned bit 0 as 1 since the flag last rose. A write of 1, or a write of 0 with no such read, leaves the flag unchanged. A write of 0 uses up the read, whether or not it clears.
- R4: A character start sets bit 1. Bit 1 is cleared by a write of 0 to bit 1 under the same read-before-write rule as R3, or by a DMA acknowledge.
- R5: While transmit enable is 0 and the error-signal status is 0, bit 2 reads 1 from the next cycle on.
- R6: While enabled, bit 2 is set one cycle after the half-etu tick that completes the guard delay, if bit 1 is 1 in that cycle. The delay counts from the character start. It is 5 ticks with both mode bits 0, 3 ticks with the GSM mode bit 0 and the block mode bit 1, and 2 ticks whenever the GSM mode bit is 1. A tick in the same cycle as the character start is not counted.
- R7: While the error-signal status is 1, neither the disabled path nor the delay path sets bit 2.
- R8: Bit 2 is cleared by an accepted software clear of bit 1, or by a DMA acknowledge. Writes to bit 2 itself have no effect.
- R9: When a set event and a clear event hit the same flag in the same cycle, the flag ends up 1.
- R10: A character start while a delay is running restarts the count from the full delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| tx_en_i | input | 1 | Transmit enable |
| gsm_mode_i | input | 1 | Short guard (GSM-style) mode select |
| blk_mode_i | input | 1 | Block transfer mode select |
| char_start_i | input | 1 | Pulse at the start of each transmitted character |
| half_etu_tick_i | input | 1 | Pulse every half element time unit |
| rx_parity_err_i | input | 1 | Pulse on a detected parity error |
| err_sig_i | input | 1 | Error-signal status (1 = error signal seen) |
| dma_ack_i | input | 1 | DMA engine has written the next data byte |
| reg_rd_i | input | 1 | Status read strobe |
| reg_wr_i | input | 1 | Status write strobe |
| reg_wdata_i | input | 3 | Write data, same bit layout as status_o |
| status_o | output | 3 | {transmit end, data empty, parity error} |

## Verification
The properties assume that every event input is a single-cycle synchronous pulse with no X after reset. They also assume that the error-signal status and the mode bits are plain levels that the block samples every cycle. The mode bits may change at any time, and the delay in force is the one the bits select at the character start. The random stimulus drives all inputs from the bench at the falling edge, with fixed-probability pulses for the events. It holds the enable and the error status mostly at their common values, so the delay path completes often, and lets the rare values through.

// File: rtl/sc_tx_pkg.sv
package sc_tx_pkg;
    // Bit positions inside the status / write-data word
    localparam int FLG_PER  = 0;
    localparam int FLG_TDRE = 1;
    localparam int FLG_TEND = 2;
    localparam int NUM_FLG  = 3;
    // Flags that software clears with the read-then-write-0 rule
    localparam int NUM_CLR  = 2;

    typedef struct packed {
        logic flag;
        logic armed;
    } clr_flag_t;
endpackage

// File: rtl/sc_clr_flag.sv
module sc_clr_flag #(
    parameter logic RST_VAL = 1'b0
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic set_i,
    input  logic hw_clr_i,
    input  logic rd_i,
    input  logic wr_i,
    input  logic wr_bit_i,
    output logic flag_o,
    output logic sw_clr_o
);
    import sc_tx_pkg::*;

    clr_flag_t st_d, st_q;
    logic      wr_zero;

    always_comb begin
        st_d     = st_q;
        wr_zero  = wr_i & ~wr_bit_i;
        sw_clr_o = wr_zero & st_q.armed & st_q.flag;
        // set has priority over every clear
        st_d.flag = set_i | (st_q.flag & ~(sw_clr_o | hw_clr_i));
        if (!st_d.flag) begin
            st_d.armed = 1'b0;
        end else if (wr_zero) begin
            st_d.armed = 1'b0;
        end else if (rd_i && st_q.flag) begin
            st_d.armed = 1'b1;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '{flag: RST_VAL, armed: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign flag_o = st_q.flag;
endmodule

// File: rtl/sc_etu_timer.sv
module sc_etu_timer #(
    parameter int CNT_W   = 4,
    parameter int DLY_STD = 5,
    parameter int DLY_BLK = 3,
    parameter int DLY_GSM = 2
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic en_i,
    input  logic start_i,
    input  logic tick_i,
    input  logic gsm_i,
    input  logic blk_i,
    output logic expire_o
);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             busy;
    } tmr_t;

    tmr_t             st_d, st_q;
    logic [CNT_W-1:0] target;

    always_comb begin
        if (gsm_i) begin
            target = CNT_W'(DLY_GSM);
        end else if (blk_i) begin
            target = CNT_W'(DLY_BLK);
        end else begin
            target = CNT_W'(DLY_STD);
        end
    end

    always_comb begin
        st_d     = st_q;
        expire_o = 1'b0;
        if (!en_i) begin
            st_d.busy = 1'b0;
        end else if (start_i) begin
            st_d.cnt  = target;
            st_d.busy = 1'b1;
        end else if (st_q.busy && tick_i) begin
            if (st_q.cnt == LAST) begin
                st_d.busy = 1'b0;
                expire_o  = 1'b1;
            end else begin
                st_d.cnt = st_q.cnt - CNT_W'(1);
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '{cnt: '0, busy: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end
endmodule

// File: rtl/sc_tx_status.sv
module sc_tx_status #(
    parameter int CNT_W   = 4,
    parameter int DLY_STD = 5,
    parameter int DLY_BLK = 3,
    parameter int DLY_GSM = 2
) (
    input  logic       clk_i,
    input  logic       rst_ni,
    input  logic       tx_en_i,
    input  logic       gsm_mode_i,
    input  logic       blk_mode_i,
    input  logic       char_start_i,
    input  logic       half_etu_tick_i,
    input  logic       rx_parity_err_i,
    input  logic       err_sig_i,
    input  logic       dma_ack_i,
    input  logic       reg_rd_i,
    input  logic       reg_wr_i,
    input  logic [2:0] reg_wdata_i,
    output logic [2:0] status_o
);
    import sc_tx_pkg::*;

    logic [NUM_CLR-1:0] set_v, hwclr_v, flag_v, swclr_v;
    logic               expire;
    logic               tend_d, tend_q;
    logic               tend_set, tend_clr;

    assign set_v[FLG_PER]    = rx_parity_err_i;
    assign hwclr_v[FLG_PER]  = 1'b0;
    assign set_v[FLG_TDRE]   = char_start_i;
    assign hwclr_v[FLG_TDRE] = dma_ack_i;

    for (genvar i = 0; i < NUM_CLR; i++) begin : g_flag
        sc_clr_flag #(
            .RST_VAL (logic'(i == FLG_TDRE))
        ) u_flag (
            .clk_i    (clk_i),
            .rst_ni   (rst_ni),
            .set_i    (set_v[i]),
            .hw_clr_i (hwclr_v[i]),
            .rd_i     (reg_rd_i),
            .wr_i     (reg_wr_i),
            .wr_bit_i (reg_wdata_i[i]),
            .flag_o   (flag_v[i]),
            .sw_clr_o (swclr_v[i])
        );
    end

    sc_etu_timer #(
        .CNT_W   (CNT_W),
        .DLY_STD (DLY_STD),
        .DLY_BLK (DLY_BLK),
        .DLY_GSM (DLY_GSM)
    ) u_timer (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .en_i     (tx_en_i),
        .start_i  (char_start_i),
        .tick_i   (half_etu_tick_i),
        .gsm_i    (gsm_mode_i),
        .blk_i    (blk_mode_i),
        .expire_o (expire)
    );

    always_comb begin
        tend_set = ~err_sig_i & ((~tx_en_i) | (expire & flag_v[FLG_TDRE]));
        tend_clr = swclr_v[FLG_TDRE] | dma_ack_i;
        tend_d   = tend_set | (tend_q & ~tend_clr);
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            tend_q <= 1'b1;
        end else begin
            tend_q <= tend_d;
        end
    end

    assign status_o = {tend_q, flag_v[FLG_TDRE], flag_v[FLG_PER]};
endmodule

// File: rtl/sc_tx_status_chk.sv
module sc_tx_status_chk (
    input logic       clk_i,
    input logic       rst_ni,
    input logic       tx_en_i,
    input logic       gsm_mode_i,
    input logic       blk_mode_i,
    input logic       char_start_i,
    input logic       half_etu_tick_i,
    input logic       rx_parity_err_i,
    input logic       err_sig_i,
    input logic       dma_ack_i,
    input logic       reg_rd_i,
    input logic       reg_wr_i,
    input logic [2:0] reg_wdata_i,
    input logic [2:0] status_o
);
    p_per_rise_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(status_o[0]) |-> $past(rx_parity_err_i));

    p_per_fall_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $fell(status_o[0]) |-> $past(reg_wr_i && !reg_wdata_i[0]));

    p_tdre_rise_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(status_o[1]) |-> $past(char_start_i));

    p_tdre_fall_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $fell(status_o[1]) |-> $past(dma_ack_i || (reg_wr_i && !reg_wdata_i[1])));

    p_tend_forced_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!tx_en_i && !err_sig_i) |=> status_o[2]);

    p_tend_needs_empty_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(status_o[2]) |-> $past(!tx_en_i || status_o[1]));

    p_tend_err_block_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(status_o[2]) |-> $past(!err_sig_i));

    p_tend_fall_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $fell(status_o[2]) |-> $past(dma_ack_i || (reg_wr_i && !reg_wdata_i[1])));

    p_set_wins_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (rx_parity_err_i || char_start_i) |=>
            ($past(rx_parity_err_i) -> status_o[0]) && ($past(char_start_i) -> status_o[1]));
endmodule

bind sc_tx_status sc_tx_status_chk u_chk (.*);

// File: tb/tb_sc_tx_status.sv
module tb_sc_tx_status;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tx_en = 1'b0, gsm = 1'b0, blk = 1'b0;
    logic       start = 1'b0, tick = 1'b0, perr = 1'b0, errs = 1'b0, dma = 1'b0;
    logic       rd = 1'b0, wr = 1'b0;
    logic [2:0] wd = 3'b111;
    logic [2:0] status;

    int checks = 0, failures = 0;
    bit done = 1'b0;

    // reference state
    logic m_per, m_tdre, m_tend, m_arm0, m_arm1, m_busy;
    int   m_cnt;

    always #(CLK_PERIOD/2) clk = ~clk;

    sc_tx_status dut (
        .clk_i(clk), .rst_ni(rst_n), .tx_en_i(tx_en), .gsm_mode_i(gsm),
        .blk_mode_i(blk), .char_start_i(start), .half_etu_tick_i(tick),
        .rx_parity_err_i(perr), .err_sig_i(errs), .dma_ack_i(dma),
        .reg_rd_i(rd), .reg_wr_i(wr), .reg_wdata_i(wd), .status_o(status)
    );

    function automatic int delay_of(logic g, logic b);
        if (g) return 2;
        if (b) return 3;
        return 5;
    endfunction

    task automatic chk(string req, logic [2:0] got, logic [2:0] exp);
        checks++;
        if (got !== exp) begin
            failures++;
            $display("FAIL %s got=%b exp=%b at %0t", req, got, exp, $time);
        end
    endtask

    task automatic model_step();
        logic per_clr, tdre_clr, expire, tend_set;
        logic per_n, tdre_n;
        per_clr  = wr && !wd[0] && m_arm0 && m_per;
        tdre_clr = (wr && !wd[1] && m_arm1 && m_tdre) || dma;
        per_n    = perr || (m_per && !per_clr);
        tdre_n   = start || (m_tdre && !tdre_clr);
        expire   = tx_en && m_busy && tick && (m_cnt == 1) && !start;
        tend_set = !errs && (!tx_en || (expire && m_tdre));
        m_tend   = tend_set || (m_tend && !tdre_clr);
        m_arm0   = !per_n ? 1'b0 : (wr && !wd[0]) ? 1'b0 : (rd && m_per) ? 1'b1 : m_arm0;
        m_arm1   = !tdre_n ? 1'b0 : (wr && !wd[1]) ? 1'b0 : (rd && m_tdre) ? 1'b1 : m_arm1;
        m_per    = per_n;
        m_tdre   = tdre_n;
        if (!tx_en) m_busy = 1'b0;
        else if (start) begin m_cnt = delay_of(gsm, blk); m_busy = 1'b1; end
        else if (m_busy && tick) begin
            if (m_cnt == 1) m_busy = 1'b0;
            else m_cnt = m_cnt - 1;
        end
    endtask

    // one clock: inputs already driven; advance model, clock, compare, clear pulses
    task automatic cyc();
        model_step();
        @(posedge clk);
        #1;
        chk("R2,R3,R4,R5,R6,R7,R8 model", status, {m_tend, m_tdre, m_per});
        @(negedge clk);
        start = 0; tick = 0; perr = 0; dma = 0; rd = 0; wr = 0; wd = 3'b111;
    endtask

    task automatic delay_run(logic g, logic b, logic err_end, string req);
        int n;
        n = delay_of(g, b);
        tx_en = 1; errs = 0; gsm = g; blk = b;
        dma = 1; cyc();
        chk({req, " cleared before start"}, status & 3'b110, 3'b000);
        start = 1; cyc();
        for (int k = 1; k <= n; k++) begin
            tick = 1;
            if (k == n) errs = err_end;
            cyc();
            if (k < n) chk({req, " before delay"}, {2'b00, status[2]}, 3'b000);
        end
        chk({req, " at delay"}, {2'b00, status[2]}, {2'b00, !err_end});
        errs = 0;
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5eed_1234));
        m_per = 0; m_tdre = 1; m_tend = 1; m_arm0 = 0; m_arm1 = 0; m_busy = 0; m_cnt = 0;
        repeat (3) @(negedge clk);
        chk("R1 reset", status, 3'b110);
        rst_n = 1;
        @(negedge clk);
        chk("R1 after release", status, 3'b110);

        // R6: delay per mode combination
        delay_run(1'b0, 1'b0, 1'b0, "R6 std 5");
        delay_run(1'b0, 1'b1, 1'b0, "R6 blk 3");
        delay_run(1'b1, 1'b0, 1'b0, "R6 gsm 2");
        delay_run(1'b1, 1'b1, 1'b0, "R6 gsm+blk 2");
        // R7: error status at expiry blocks the set
        delay_run(1'b0, 1'b0, 1'b1, "R7 err at expiry");

        // R10: restart mid-delay
        tx_en = 1; gsm = 0; blk = 0; dma = 1; cyc();
        start = 1; cyc();
        repeat (3) begin tick = 1; cyc(); end
        start = 1; cyc();
        repeat (4) begin tick = 1; cyc(); end
        chk("R10 restart not yet", {2'b00, status[2]}, 3'b000);
        tick = 1; cyc();
        chk("R10 restart full delay", {2'b00, status[2]}, 3'b001);

        // R6: data register not empty at expiry -> no set
        start = 1; cyc();
        dma = 1; cyc();
        repeat (5) begin tick = 1; cyc(); end
        chk("R6 tdre 0 blocks", status & 3'b110, 3'b000);

        // R7: disabled with error status does not force
        tx_en = 0; errs = 1; cyc(); cyc();
        chk("R7 disabled err", {2'b00, status[2]}, 3'b000);
        // R5: disabled, no error -> forced
        errs = 0; cyc();
        chk("R5 forced", {2'b00, status[2]}, 3'b001);
        tx_en = 1;

        // R3: parity flag clear rules
        perr = 1; cyc();
        chk("R2 parity set", {2'b00, status[0]}, 3'b001);
        wr = 1; wd = 3'b110; cyc();
        chk("R3 unarmed write 0", {2'b00, status[0]}, 3'b001);
        rd = 1; cyc();
        wr = 1; wd = 3'b111; cyc();
        chk("R3 write 1 ignored", {2'b00, status[0]}, 3'b001);
        wr = 1; wd = 3'b110; cyc();
        chk("R3 armed clear", {2'b00, status[0]}, 3'b000);
        // R9: set beats clear
        perr = 1; cyc();
        rd = 1; cyc();
        wr = 1; wd = 3'b110; perr = 1; cyc();
        chk("R9 set wins", {2'b00, status[0]}, 3'b001);

        // R4/R8: software clear of data-empty also clears transmit end
        tx_en = 0; cyc(); tx_en = 1;
        start = 1; cyc();
        rd = 1; cyc();
        wr = 1; wd = 3'b011; cyc();
        chk("R8 bit2 write ignored", status & 3'b110, 3'b110);
        rd = 1; cyc();
        wr = 1; wd = 3'b101; cyc();
        chk("R4 R8 sw clear", status & 3'b110, 3'b000);
        start = 1; cyc();
        chk("R4 start sets empty", status & 3'b010, 3'b010);

        // constrained random phase
        for (int i = 0; i < 4000; i++) begin
            tx_en = ($urandom_range(0, 19) != 0);
            errs  = ($urandom_range(0, 9) == 0);
            if ($urandom_range(0, 63) == 0) begin gsm = 1'($urandom); blk = 1'($urandom); end
            start = ($urandom_range(0, 11) == 0);
            tick  = ($urandom_range(0, 2) == 0);
            perr  = ($urandom_range(0, 24) == 0);
            dma   = ($urandom_range(0, 29) == 0);
            rd    = ($urandom_range(0, 3) == 0);
            wr    = ($urandom_range(0, 5) == 0);
            wd    = 3'($urandom);
            cyc();
        end

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule